// File: doc/BRIEF.md
# Bidirectional Ring Stop

This block is one station on a pair of rings that carry whole-cache-line packets between on-chip agents (cores, a memory controller, an accelerator, I/O). One ring moves traffic towards higher stop numbers (clockwise) and the other towards lower stop numbers (counter-clockwise). Each ring has one slot register per station, so a packet moves one station per clock and never waits. Everything runs in a single clock domain.

The local agent hands packets over on a valid/ready inject channel and takes delivered packets from a valid/ready eject channel. For each packet the station works out which ring reaches the destination in fewer hops and injects there, as long as that ring's incoming slot is empty or is being ejected at this station in the same cycle. Traffic already on a ring always has priority. A packet addressed to this station appears on the eject port in the cycle it arrives. If the agent stalls, the packet stays on its ring and comes back one full lap later. When both rings bring a packet for this station in the same cycle, the ejection alternates between the rings.

Top module: `ring_stop`

## Requirements
- R1: A packet arriving at an upstream port whose destination is not this station leaves the matching downstream port on the next clock, with destination, source and payload unchanged. On the clockwise ring station i feeds station (i+1) mod NUM_STOPS. On the counter-clockwise ring station i feeds station (i-1) mod NUM_STOPS.
- R2: A packet is a valid bit, a destination ID, a source ID and a DATA_W-bit payload (512 by default, one cache line). An injected packet leaves with source ID equal to STOP_ID and with the destination and payload that were offered.
- R3: An incoming packet whose destination equals STOP_ID raises ejValid in the same cycle, with its source and payload on ejSrc/ejData. ejRing is 0 for the clockwise ring and 1 for the counter-clockwise ring. When ejReady is high, the packet is removed from the ring.
- R4: While ejReady is low, a packet addressed to this station is forwarded downstream and shows up at this station again NUM_STOPS cycles later.
- R5: The clockwise hop count is (dst-STOP_ID) mod NUM_STOPS and the counter-clockwise hop count is (STOP_ID-dst) mod NUM_STOPS. The counter-clockwise ring is used only when its count is strictly smaller. A packet addressed to its own sender goes a full lap clockwise.
- R6: injReady is low while the incoming slot of the chosen ring holds a packet that is not being ejected here. Passing traffic is never dropped or delayed.
- R7: In a cycle where the chosen ring's incoming packet is ejected (ejValid and ejReady), injReady is high and the new packet takes the freed slot.
- R8: When both rings present a packet for this station in the same cycle, ejections alternate between the rings. The first such contention after reset goes to the clockwise ring, and the losing packet goes round again.
- R9: On idle rings, the eject handshake at the destination comes exactly d cycles after the inject handshake, where d is the shorter hop count (NUM_STOPS for a self-addressed packet). Each packet is ejected exactly once, at its destination only.
- R10: During reset, both downstream ports carry no valid packet and ejValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cwInValid | input | 1 | Clockwise upstream slot occupied |
| cwInDst | input | ID_W | Clockwise upstream destination ID |
| cwInSrc | input | ID_W | Clockwise upstream source ID |
| cwInData | input | DATA_W | Clockwise upstream payload |
| cwOutValid | output | 1 | Clockwise downstream slot occupied |
| cwOutDst | output | ID_W | Clockwise downstream destination ID |
| cwOutSrc | output | ID_W | Clockwise downstream source ID |
| cwOutData | output | DATA_W | Clockwise downstream payload |
| ccwInValid | input | 1 | Counter-clockwise upstream slot occupied |
| ccwInDst | input | ID_W | Counter-clockwise upstream destination ID |
| ccwInSrc | input | ID_W | Counter-clockwise upstream source ID |
| ccwInData | input | DATA_W | Counter-clockwise upstream payload |
| ccwOutValid | output | 1 | Counter-clockwise downstream slot occupied |
| ccwOutDst | output | ID_W | Counter-clockwise downstream destination ID |
| ccwOutSrc | output | ID_W | Counter-clockwise downstream source ID |
| ccwOutData | output | DATA_W | Counter-clockwise downstream payload |
| injValid | input | 1 | Local agent offers a packet |
| injReady | output | 1 | Station accepts the offered packet this cycle |
| injDst | input | ID_W | Destination of the offered packet |
| injData | input | DATA_W | Payload of the offered packet |
| ejValid | output | 1 | Packet for the local agent available |
| ejReady | input | 1 | Local agent takes the packet |
| ejRing | output | 1 | Ring the ejected packet came from (0 clockwise, 1 counter-clockwise) |
| ejSrc | output | ID_W | Source ID of the ejected packet |
| ejData | output | DATA_W | Payload of the ejected packet |

## Verification
The bench builds a five-station ring and sends a packet between every ordered pair of stations. It checks the ring chosen, the latency in cycles and that the packet arrives exactly once. A wrong modulo or a tie-break to the wrong side would show up as a longer latency or the wrong ejRing, and an off-by-one in the slot stage would shift every latency. Targeted cases go after a stalled eject (a design that drops the packet never sees it come back a lap later), injection that clashes with passing traffic (an overwrite corrupts the passing packet or lets injReady rise too early), injection into a slot freed by ejection, and two contentions in a row at one station, where a fixed-priority arbiter would grant the same ring twice.

// File: rtl/ring_stop_pkg.sv
package ring_stop_pkg;

  typedef enum logic {
    RING_CW  = 1'b0,
    RING_CCW = 1'b1
  } ringDir_e;

  // strobes from control to the slot datapath
  typedef struct packed {
    logic cwEject;
    logic ccwEject;
    logic cwInject;
    logic ccwInject;
    logic ejFromCcw;
  } stopCtl_t;

endpackage

// File: rtl/ring_stop_ctrl.sv
module ring_stop_ctrl
  import ring_stop_pkg::*;
#(
  parameter int NUM_STOPS = 8,
  parameter int STOP_ID   = 0,
  parameter int ID_W      = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cwInValid,
  input  logic [ID_W-1:0] cwInDst,
  input  logic            ccwInValid,
  input  logic [ID_W-1:0] ccwInDst,
  input  logic            injValid,
  input  logic [ID_W-1:0] injDst,
  input  logic            ejReady,
  output logic            injReady,
  output logic            ejValid,
  output stopCtl_t        ctl
);

  localparam int HOP_W = ID_W + 1;
  localparam logic [HOP_W-1:0] NUM_H = HOP_W'(NUM_STOPS);
  localparam logic [HOP_W-1:0] ID_H  = HOP_W'(STOP_ID);
  localparam logic [ID_W-1:0]  MY_ID = ID_W'(STOP_ID);

  logic [HOP_W-1:0] dstH, cwHops, ccwHops;
  logic cwHit, ccwHit, grantCcw, ejFire;
  logic cwFree, ccwFree, useCcw;
  ringDir_e rrPtr;

  // route selection: shorter path, ties and self-addressed go clockwise
  always_comb begin
    dstH    = {1'b0, injDst};
    cwHops  = (dstH >= ID_H) ? (dstH - ID_H) : (dstH + NUM_H - ID_H);
    ccwHops = (ID_H >= dstH) ? (ID_H - dstH) : (ID_H + NUM_H - dstH);
    useCcw  = (ccwHops != '0) && (ccwHops < cwHops);
  end

  // eject arbitration between the two rings
  always_comb begin
    cwHit    = cwInValid  && (cwInDst  == MY_ID);
    ccwHit   = ccwInValid && (ccwInDst == MY_ID);
    grantCcw = ccwHit && (!cwHit || (rrPtr == RING_CCW));
    ejValid  = cwHit || ccwHit;
    ejFire   = ejValid && ejReady;
  end

  // injection gating: ring traffic first
  always_comb begin
    ctl.cwEject   = ejFire && !grantCcw;
    ctl.ccwEject  = ejFire && grantCcw;
    ctl.ejFromCcw = grantCcw;
    cwFree        = !cwInValid  || ctl.cwEject;
    ccwFree       = !ccwInValid || ctl.ccwEject;
    injReady      = useCcw ? ccwFree : cwFree;
    ctl.cwInject  = injValid && injReady && !useCcw;
    ctl.ccwInject = injValid && injReady && useCcw;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= RING_CW;
    end else if (ejFire && cwHit && ccwHit) begin
      rrPtr <= grantCcw ? RING_CW : RING_CCW;
    end
  end

endmodule

// File: rtl/ring_stop_dp.sv
module ring_stop_dp
  import ring_stop_pkg::*;
#(
  parameter int STOP_ID = 0,
  parameter int ID_W    = 3,
  parameter int DATA_W  = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  stopCtl_t          ctl,
  input  logic              cwInValid,
  input  logic [ID_W-1:0]   cwInDst,
  input  logic [ID_W-1:0]   cwInSrc,
  input  logic [DATA_W-1:0] cwInData,
  input  logic              ccwInValid,
  input  logic [ID_W-1:0]   ccwInDst,
  input  logic [ID_W-1:0]   ccwInSrc,
  input  logic [DATA_W-1:0] ccwInData,
  input  logic [ID_W-1:0]   injDst,
  input  logic [DATA_W-1:0] injData,
  output logic              cwOutValid,
  output logic [ID_W-1:0]   cwOutDst,
  output logic [ID_W-1:0]   cwOutSrc,
  output logic [DATA_W-1:0] cwOutData,
  output logic              ccwOutValid,
  output logic [ID_W-1:0]   ccwOutDst,
  output logic [ID_W-1:0]   ccwOutSrc,
  output logic [DATA_W-1:0] ccwOutData,
  output logic [ID_W-1:0]   ejSrc,
  output logic [DATA_W-1:0] ejData
);

  localparam int NUM_RINGS = 2;
  localparam logic [ID_W-1:0] MY_ID = ID_W'(STOP_ID);

  typedef struct packed {
    logic              valid;
    logic [ID_W-1:0]   dst;
    logic [ID_W-1:0]   src;
    logic [DATA_W-1:0] data;
  } ringPkt_t;

  ringPkt_t inPkt  [NUM_RINGS];
  ringPkt_t slot   [NUM_RINGS];
  logic [NUM_RINGS-1:0] injVec, ejVec;
  ringPkt_t newPkt;

  assign inPkt[0] = '{valid: cwInValid,  dst: cwInDst,  src: cwInSrc,  data: cwInData};
  assign inPkt[1] = '{valid: ccwInValid, dst: ccwInDst, src: ccwInSrc, data: ccwInData};
  assign injVec   = {ctl.ccwInject, ctl.cwInject};
  assign ejVec    = {ctl.ccwEject, ctl.cwEject};
  assign newPkt   = '{valid: 1'b1, dst: injDst, src: MY_ID, data: injData};

  for (genvar r = 0; r < NUM_RINGS; r++) begin : gen_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slot[r] <= '0;
      end else if (injVec[r]) begin
        slot[r] <= newPkt;
      end else if (ejVec[r]) begin
        slot[r].valid <= 1'b0;
      end else begin
        slot[r] <= inPkt[r];
      end
    end
  end

  assign cwOutValid  = slot[0].valid;
  assign cwOutDst    = slot[0].dst;
  assign cwOutSrc    = slot[0].src;
  assign cwOutData   = slot[0].data;
  assign ccwOutValid = slot[1].valid;
  assign ccwOutDst   = slot[1].dst;
  assign ccwOutSrc   = slot[1].src;
  assign ccwOutData  = slot[1].data;

  assign ejSrc  = ctl.ejFromCcw ? inPkt[1].src  : inPkt[0].src;
  assign ejData = ctl.ejFromCcw ? inPkt[1].data : inPkt[0].data;

endmodule

// File: rtl/ring_stop.sv
module ring_stop
  import ring_stop_pkg::*;
#(
  parameter  int NUM_STOPS = 8,
  parameter  int STOP_ID   = 0,
  parameter  int DATA_W    = 512,
  localparam int ID_W      = (NUM_STOPS > 1) ? $clog2(NUM_STOPS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cwInValid,
  input  logic [ID_W-1:0]   cwInDst,
  input  logic [ID_W-1:0]   cwInSrc,
  input  logic [DATA_W-1:0] cwInData,
  output logic              cwOutValid,
  output logic [ID_W-1:0]   cwOutDst,
  output logic [ID_W-1:0]   cwOutSrc,
  output logic [DATA_W-1:0] cwOutData,
  input  logic              ccwInValid,
  input  logic [ID_W-1:0]   ccwInDst,
  input  logic [ID_W-1:0]   ccwInSrc,
  input  logic [DATA_W-1:0] ccwInData,
  output logic              ccwOutValid,
  output logic [ID_W-1:0]   ccwOutDst,
  output logic [ID_W-1:0]   ccwOutSrc,
  output logic [DATA_W-1:0] ccwOutData,
  input  logic              injValid,
  output logic              injReady,
  input  logic [ID_W-1:0]   injDst,
  input  logic [DATA_W-1:0] injData,
  output logic              ejValid,
  input  logic              ejReady,
  output logic              ejRing,
  output logic [ID_W-1:0]   ejSrc,
  output logic [DATA_W-1:0] ejData
);

  stopCtl_t ctl;

  ring_stop_ctrl #(
    .NUM_STOPS(NUM_STOPS),
    .STOP_ID  (STOP_ID),
    .ID_W     (ID_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cwInValid (cwInValid),
    .cwInDst   (cwInDst),
    .ccwInValid(ccwInValid),
    .ccwInDst  (ccwInDst),
    .injValid  (injValid),
    .injDst    (injDst),
    .ejReady   (ejReady),
    .injReady  (injReady),
    .ejValid   (ejValid),
    .ctl       (ctl)
  );

  ring_stop_dp #(
    .STOP_ID(STOP_ID),
    .ID_W   (ID_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .cwInValid  (cwInValid),
    .cwInDst    (cwInDst),
    .cwInSrc    (cwInSrc),
    .cwInData   (cwInData),
    .ccwInValid (ccwInValid),
    .ccwInDst   (ccwInDst),
    .ccwInSrc   (ccwInSrc),
    .ccwInData  (ccwInData),
    .injDst     (injDst),
    .injData    (injData),
    .cwOutValid (cwOutValid),
    .cwOutDst   (cwOutDst),
    .cwOutSrc   (cwOutSrc),
    .cwOutData  (cwOutData),
    .ccwOutValid(ccwOutValid),
    .ccwOutDst  (ccwOutDst),
    .ccwOutSrc  (ccwOutSrc),
    .ccwOutData (ccwOutData),
    .ejSrc      (ejSrc),
    .ejData     (ejData)
  );

  assign ejRing = ctl.ejFromCcw;

endmodule

// File: rtl/ring_stop_chk.sv
module ring_stop_chk #(
  parameter  int NUM_STOPS = 8,
  parameter  int STOP_ID   = 0,
  parameter  int DATA_W    = 512,
  localparam int ID_W      = (NUM_STOPS > 1) ? $clog2(NUM_STOPS) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              cwInValid,
  input logic [ID_W-1:0]   cwInDst,
  input logic [ID_W-1:0]   cwInSrc,
  input logic [DATA_W-1:0] cwInData,
  input logic              cwOutValid,
  input logic [ID_W-1:0]   cwOutDst,
  input logic [ID_W-1:0]   cwOutSrc,
  input logic [DATA_W-1:0] cwOutData,
  input logic              ccwInValid,
  input logic [ID_W-1:0]   ccwInDst,
  input logic [ID_W-1:0]   ccwInSrc,
  input logic [DATA_W-1:0] ccwInData,
  input logic              ccwOutValid,
  input logic [ID_W-1:0]   ccwOutDst,
  input logic [ID_W-1:0]   ccwOutSrc,
  input logic [DATA_W-1:0] ccwOutData,
  input logic              injValid,
  input logic              injReady,
  input logic [ID_W-1:0]   injDst,
  input logic [DATA_W-1:0] injData,
  input logic              ejValid,
  input logic              ejReady,
  input logic              ejRing,
  input logic [ID_W-1:0]   ejSrc,
  input logic [DATA_W-1:0] ejData
);

  localparam logic [ID_W-1:0] MY_ID = ID_W'(STOP_ID);

  logic bothHit, seenCont, lastCont;
  assign bothHit = cwInValid && (cwInDst == MY_ID) && ccwInValid && (ccwInDst == MY_ID);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenCont <= 1'b0;
      lastCont <= 1'b0;
    end else if (bothHit && ejReady) begin
      seenCont <= 1'b1;
      lastCont <= ejRing;
    end
  end

  p_fwd_cw_r1: assert property (@(posedge clk) disable iff (!rstN)
    cwInValid && (cwInDst != MY_ID) |=> cwOutValid && cwOutDst == $past(cwInDst)
      && cwOutSrc == $past(cwInSrc) && cwOutData == $past(cwInData));

  p_fwd_ccw_r1: assert property (@(posedge clk) disable iff (!rstN)
    ccwInValid && (ccwInDst != MY_ID) |=> ccwOutValid && ccwOutDst == $past(ccwInDst)
      && ccwOutSrc == $past(ccwInSrc) && ccwOutData == $past(ccwInData));

  p_inject_fmt_r2: assert property (@(posedge clk) disable iff (!rstN)
    injValid && injReady |=>
      (cwOutValid && cwOutSrc == MY_ID && cwOutDst == $past(injDst) && cwOutData == $past(injData))
      || (ccwOutValid && ccwOutSrc == MY_ID && ccwOutDst == $past(injDst) && ccwOutData == $past(injData)));

  p_eject_sel_r3: assert property (@(posedge clk) disable iff (!rstN)
    ejValid |-> (ejRing
      ? (ccwInValid && ccwInDst == MY_ID && ejData == ccwInData && ejSrc == ccwInSrc)
      : (cwInValid && cwInDst == MY_ID && ejData == cwInData && ejSrc == cwInSrc)));

  p_eject_removed_r3: assert property (@(posedge clk) disable iff (!rstN)
    ejValid && ejReady && !ejRing |=> !cwOutValid || $past(injValid && injReady));

  p_stall_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    cwInValid && (cwInDst == MY_ID) && !ejReady |=> cwOutValid && cwOutData == $past(cwInData));

  p_rr_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    bothHit && ejReady && !seenCont |-> !ejRing);

  p_rr_alternate_r8: assert property (@(posedge clk) disable iff (!rstN)
    bothHit && ejReady && seenCont |-> ejRing != lastCont);

endmodule

bind ring_stop ring_stop_chk #(
  .NUM_STOPS(NUM_STOPS),
  .STOP_ID  (STOP_ID),
  .DATA_W   (DATA_W)
) u_chk (.*);

// File: tb/ring_stop_tb.sv
module ring_stop_tb;

  localparam int N   = 5;
  localparam int IDW = $clog2(N);
  localparam int DW  = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic           cwV [N];
  logic [IDW-1:0] cwD [N];
  logic [IDW-1:0] cwS [N];
  logic [DW-1:0]  cwP [N];
  logic           ccwV[N];
  logic [IDW-1:0] ccwD[N];
  logic [IDW-1:0] ccwS[N];
  logic [DW-1:0]  ccwP[N];
  logic           injValid[N];
  logic           injReady[N];
  logic [IDW-1:0] injDst  [N];
  logic [DW-1:0]  injData [N];
  logic           ejValid [N];
  logic           ejReady [N];
  logic           ejRing  [N];
  logic [IDW-1:0] ejSrc   [N];
  logic [DW-1:0]  ejData  [N];

  for (genvar i = 0; i < N; i++) begin : gen_stop
    localparam int UP_CW  = (i + N - 1) % N;
    localparam int UP_CCW = (i + 1) % N;
    ring_stop #(.NUM_STOPS(N), .STOP_ID(i), .DATA_W(DW)) u_dut (
      .clk(clk), .rstN(rstN),
      .cwInValid(cwV[UP_CW]), .cwInDst(cwD[UP_CW]), .cwInSrc(cwS[UP_CW]), .cwInData(cwP[UP_CW]),
      .cwOutValid(cwV[i]), .cwOutDst(cwD[i]), .cwOutSrc(cwS[i]), .cwOutData(cwP[i]),
      .ccwInValid(ccwV[UP_CCW]), .ccwInDst(ccwD[UP_CCW]), .ccwInSrc(ccwS[UP_CCW]), .ccwInData(ccwP[UP_CCW]),
      .ccwOutValid(ccwV[i]), .ccwOutDst(ccwD[i]), .ccwOutSrc(ccwS[i]), .ccwOutData(ccwP[i]),
      .injValid(injValid[i]), .injReady(injReady[i]), .injDst(injDst[i]), .injData(injData[i]),
      .ejValid(ejValid[i]), .ejReady(ejReady[i]), .ejRing(ejRing[i]), .ejSrc(ejSrc[i]), .ejData(ejData[i])
    );
  end

  int checks = 0;
  int fails  = 0;
  int ejFires[N];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // eject handshake monitor, sampled mid-cycle
  initial begin
    for (int i = 0; i < N; i++) ejFires[i] = 0;
    forever begin
      @(negedge clk);
      #5;
      for (int i = 0; i < N; i++) if (ejValid[i] && ejReady[i]) ejFires[i]++;
    end
  end

  function automatic int totalFires();
    int t = 0;
    for (int i = 0; i < N; i++) t += ejFires[i];
    return t;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9 watchdog expired: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  // one packet on idle rings, s -> d
  task automatic sendOne(input int s, input int d);
    int cwH, ccwH, expHops, expRing, found, t0, f0;
    logic [DW-1:0] pay, gotData;
    logic [IDW-1:0] gotSrc;
    logic gotRing;
    cwH  = (d - s + N) % N;
    ccwH = (s - d + N) % N;
    if (cwH == 0) begin expHops = N; expRing = 0; end
    else if (ccwH < cwH) begin expHops = ccwH; expRing = 1; end
    else begin expHops = cwH; expRing = 0; end
    pay = 32'hA500_0000 | DW'(s * 16 + d);
    found = 0; gotData = '0; gotSrc = '0; gotRing = 1'b0;
    t0 = totalFires(); f0 = ejFires[d];
    @(negedge clk);
    injValid[s] = 1'b1; injDst[s] = IDW'(d); injData[s] = pay;
    #1;
    check(injReady[s] == 1'b1, "R6", "ready on idle ring", injReady[s], 1);
    for (int k = 1; k <= N + 1; k++) begin
      @(negedge clk);
      if (k == 1) injValid[s] = 1'b0;
      #1;
      if (ejValid[d] && found == 0) begin
        found = k; gotData = ejData[d]; gotSrc = ejSrc[d]; gotRing = ejRing[d];
      end
    end
    @(negedge clk);
    #6;
    check(found == expHops, "R9", $sformatf("latency %0d->%0d", s, d), found, expHops);
    check(gotRing == expRing[0], "R5", $sformatf("ring %0d->%0d", s, d), gotRing, expRing);
    check(gotData == pay && gotSrc == IDW'(s), "R2", $sformatf("payload/src %0d->%0d", s, d), gotData, pay);
    check((totalFires() - t0) == 1 && (ejFires[d] - f0) == 1, "R9",
          $sformatf("delivered once %0d->%0d", s, d), totalFires() - t0, 1);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      injValid[i] = 1'b0; injDst[i] = '0; injData[i] = '0; ejReady[i] = 1'b1;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    for (int i = 0; i < N; i++)
      check(!cwV[i] && !ccwV[i] && !ejValid[i], "R10", $sformatf("reset idle stop %0d", i),
            {cwV[i], ccwV[i], ejValid[i]}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // exhaustive pair sweep: R1 R2 R3 R5 R9
    for (int s = 0; s < N; s++)
      for (int d = 0; d < N; d++)
        sendOne(s, d);

    // R8: two contentions at stop 0 (stop 4 cw 1 hop, stop 1 ccw 1 hop)
    for (int r = 0; r < 2; r++) begin
      int f0;
      logic [DW-1:0] seen [N+2];
      logic          seenV[N+2];
      logic          seenR[N+2];
      f0 = ejFires[0];
      @(negedge clk);
      injValid[4] = 1'b1; injDst[4] = '0; injData[4] = 32'hB0B0_0000 + DW'(r);
      injValid[1] = 1'b1; injDst[1] = '0; injData[1] = 32'hC0C0_0000 + DW'(r);
      #1;
      check(injReady[4] && injReady[1], "R6", "both ready before contention", {injReady[4], injReady[1]}, 3);
      for (int k = 1; k <= N + 1; k++) begin
        @(negedge clk);
        if (k == 1) begin injValid[4] = 1'b0; injValid[1] = 1'b0; end
        #1;
        seenV[k] = ejValid[0]; seenR[k] = ejRing[0]; seen[k] = ejData[0];
      end
      @(negedge clk);
      #6;
      check(seenV[1] && seenR[1] == r[0], "R8", $sformatf("contention %0d winner ring", r), seenR[1], r);
      check(seen[1] == (r == 0 ? 32'hB0B0_0000 : 32'hC0C0_0001), "R8", "winner payload",
            seen[1], (r == 0 ? 32'hB0B0_0000 : 32'hC0C0_0001));
      check(!seenV[2] && !seenV[N], "R8", "loser absent mid-lap", {seenV[2], seenV[N]}, 0);
      check(seenV[N+1] && seenR[N+1] != r[0], "R8", "loser back after lap", seenR[N+1], 1 - r);
      check((ejFires[0] - f0) == 2, "R8", "two deliveries", ejFires[0] - f0, 2);
    end

    // R4: stalled eject, 0 -> 2 clockwise (2 hops)
    begin
      int f0;
      f0 = ejFires[2];
      ejReady[2] = 1'b0;
      @(negedge clk);
      injValid[0] = 1'b1; injDst[0] = 2; injData[0] = 32'h5A5A_0002;
      for (int k = 1; k <= N + 3; k++) begin
        @(negedge clk);
        if (k == 1) injValid[0] = 1'b0;
        if (k == N + 2) ejReady[2] = 1'b1;
        #1;
        if (k == 2) check(ejValid[2] && ejData[2] == 32'h5A5A_0002, "R4", "first arrival", ejValid[2], 1);
        if (k == 3) check(!ejValid[2], "R4", "gone on its lap", ejValid[2], 0);
        if (k == N + 2) check(ejValid[2] && ejData[2] == 32'h5A5A_0002, "R4", "back after lap", ejValid[2], 1);
        if (k == N + 3) check(!ejValid[2], "R4", "removed after accept", ejValid[2], 0);
      end
      #6;
      check((ejFires[2] - f0) == 1, "R4", "single delivery", ejFires[2] - f0, 1);
    end

    // R6: stop 4 -> 1 passes stop 0 on cw; stop 0 wants cw to 2
    @(negedge clk);
    injValid[4] = 1'b1; injDst[4] = 1; injData[4] = 32'h1111_4001;
    @(negedge clk);
    injValid[4] = 1'b0;
    injValid[0] = 1'b1; injDst[0] = 2; injData[0] = 32'h2222_0002;
    #1;
    check(injReady[0] == 1'b0, "R6", "blocked by passing packet", injReady[0], 0);
    @(negedge clk);
    #1;
    check(ejValid[1] && ejData[1] == 32'h1111_4001 && ejSrc[1] == 3'd4, "R1", "passing packet intact",
          ejData[1], 32'h1111_4001);
    check(injReady[0] == 1'b1, "R6", "ready once slot empty", injReady[0], 1);
    @(negedge clk);
    injValid[0] = 1'b0;
    @(negedge clk);
    #1;
    check(ejValid[2] && ejData[2] == 32'h2222_0002, "R6", "delayed packet arrives", ejData[2], 32'h2222_0002);

    // R7: stop 1 ejects from cw and injects cw to 2 in the same cycle
    @(negedge clk);
    @(negedge clk);
    injValid[0] = 1'b1; injDst[0] = 1; injData[0] = 32'h3333_0001;
    @(negedge clk);
    injValid[0] = 1'b0;
    injValid[1] = 1'b1; injDst[1] = 2; injData[1] = 32'h4444_1002;
    ejReady[1] = 1'b0;
    #1;
    check(ejValid[1] && injReady[1] == 1'b0, "R7", "no slot while eject stalled", injReady[1], 0);
    ejReady[1] = 1'b1;
    #1;
    check(injReady[1] == 1'b1, "R7", "slot freed by eject", injReady[1], 1);
    @(negedge clk);
    injValid[1] = 1'b0;
    #1;
    check(ejValid[2] && ejData[2] == 32'h4444_1002 && !ejValid[1], "R7", "new packet in freed slot",
          ejData[2], 32'h4444_1002);

    repeat (N + 2) @(negedge clk);
    summary();
    $finish;
  end

endmodule